// File: doc/BRIEF.md
# Packed Pixel-by-Scale Multiplier

This block multiplies packed 8-bit pixel values by signed 16-bit scale factors. Both operands are 64 bits wide. The scale operand holds four signed 16-bit elements. The pixel operand is read either as eight bytes or as four 16-bit elements, depending on the variant. A 3-bit opcode chooses one of seven variants:

- five narrow variants, each giving four rounded 16-bit lanes;
- two widening variants, each giving two 32-bit lanes.

Each narrow lane keeps the middle 16 bits of its product after a round-to-nearest step on the lowest product byte. The widening lanes keep the whole rounded product. An input is accepted on any cycle where the valid strobe is high. The result and an output valid flag are registered and appear one clock later. The result is held until the next accepted input.

Top module: `simd_scale_mul`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `result` is all zero.
- R2: When `in_valid` is high at a rising edge, that input's result appears on `result` after that edge and `out_valid` is 1. When `in_valid` is low at an edge, `out_valid` is 0 after it and `result` keeps its previous value.
- R3: Every variant forms a 32-bit two's-complement product per lane. If the product's bits [7:0] are above 0x7F, 0x100 is added. A narrow lane then takes bits [23:8] of that rounded value.
- R4: Opcode 0 (per-lane) makes narrow lane r (`result[16r+15:16r]`) from the signed scale element `scl_i[16r+15:16r]` times the unsigned pixel byte `pix_i[8r+7:8r]`. Lane 0 is the least significant.
- R5: Opcode 1 uses scale element 1 (`scl_i[31:16]`) for all four lanes. The pixel bytes are read as for opcode 0.
- R6: Opcode 2 uses scale element 0 (`scl_i[15:0]`) for all four lanes. The pixel bytes are read as for opcode 0.
- R7: Opcode 3 multiplies scale element r by the signed upper byte of pixel element r, `pix_i[16r+15:16r+8]`.
- R8: Opcode 4 multiplies scale element r by the unsigned lower byte of pixel element r, `pix_i[16r+7:16r]` (byte index 2r).
- R9: Opcode 5 uses the signed upper-byte multiplicand of opcode 3, for lanes 0 and 1 only. Each rounded 32-bit product (not shifted) fills `result[32r+31:32r]`.
- R10: Opcode 6 uses the unsigned lower-byte multiplicand of opcode 4, for lanes 0 and 1 only. Each rounded 32-bit product fills `result[32r+31:32r]`.
- R11: Opcode 7 is reserved and yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept strobe for the operands and opcode |
| opcode | input | 3 | Variant select, 0 to 7 |
| pix_i | input | 64 | Packed pixel operand |
| scl_i | input | 64 | Packed signed scale operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered packed result |

## Verification
On every cycle, the assertions check:

- that the valid flag follows the strobe with a one-cycle lag;
- that the result holds when no input is accepted;
- that the reserved opcode and an all-zero pixel operand always give a zero result.

The lane arithmetic needs the bench's scenarios. These cover the rounding boundary at 0x7F and 0x80, negative scales, the choice of broadcast element, the upper-byte versus lower-byte selection, and the placement of the wide lanes. Random operands under every opcode are compared against a reference model in the bench.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [2:0] {
      PM_LANE    = 3'd0,
      PM_BC_LO   = 3'd1,
      PM_BC_HI   = 3'd2,
      PM_HI_SGN  = 3'd3,
      PM_LO_UNS  = 3'd4,
      PM_WIDE_HI = 3'd5,
      PM_WIDE_LO = 3'd6,
      PM_NONE    = 3'd7
   } pm_op_e;

   function automatic logic pm_is_wide(input pm_op_e op);
      return (op == PM_WIDE_HI) || (op == PM_WIDE_LO);
   endfunction

   function automatic logic pm_is_narrow(input pm_op_e op);
      return (op != PM_NONE) && !pm_is_wide(op);
   endfunction
endpackage

// File: rtl/pm_operand_sel.sv
module pm_operand_sel
   import pm_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int ELEM_W = 16,
   localparam int DATA_W = LANES * ELEM_W
) (
   input  pm_op_e                         op,
   input  logic [DATA_W-1:0]              pix,
   input  logic [DATA_W-1:0]              scl,
   output logic signed [ELEM_W-1:0]       scale_o [LANES],
   output logic signed [BYTE_W:0]         mcand_o [LANES]
);
   for (genvar r = 0; r < LANES; r++) begin : g_lane
      logic [BYTE_W-1:0] byte_lane, byte_hi, byte_lo;
      assign byte_lane = pix[r*BYTE_W +: BYTE_W];
      assign byte_hi   = pix[r*ELEM_W + ELEM_W - BYTE_W +: BYTE_W];
      assign byte_lo   = pix[r*ELEM_W +: BYTE_W];

      always_comb begin
         unique case (op)
            PM_BC_LO: scale_o[r] = scl[ELEM_W +: ELEM_W];
            PM_BC_HI: scale_o[r] = scl[0 +: ELEM_W];
            default:  scale_o[r] = scl[r*ELEM_W +: ELEM_W];
         endcase
      end

      always_comb begin
         unique case (op)
            PM_LANE, PM_BC_LO, PM_BC_HI: mcand_o[r] = {1'b0, byte_lane};
            PM_HI_SGN, PM_WIDE_HI:       mcand_o[r] = {byte_hi[BYTE_W-1], byte_hi};
            PM_LO_UNS, PM_WIDE_LO:       mcand_o[r] = {1'b0, byte_lo};
            default:                     mcand_o[r] = '0;
         endcase
      end
   end
endmodule

// File: rtl/pm_lane_mul.sv
module pm_lane_mul #(
   parameter int BYTE_W = 8,
   parameter int ELEM_W = 16,
   localparam int WIDE_W = 2 * ELEM_W,
   localparam int PROD_W = ELEM_W + BYTE_W + 1
) (
   input  logic signed [ELEM_W-1:0] scale,
   input  logic signed [BYTE_W:0]   mcand,
   output logic [ELEM_W-1:0]        narrow_o,
   output logic [WIDE_W-1:0]        wide_o
);
   localparam logic [BYTE_W-1:0] HALF = {1'b0, {(BYTE_W-1){1'b1}}};

   logic signed [PROD_W-1:0] prod;
   logic [WIDE_W-1:0]        prod_ext;
   logic                     round_up;
   logic [WIDE_W-1:0]        rounded;

   assign prod     = scale * mcand;
   assign prod_ext = {{(WIDE_W-PROD_W){prod[PROD_W-1]}}, prod};
   assign round_up = prod_ext[BYTE_W-1:0] > HALF;
   assign rounded  = prod_ext + (round_up ? (WIDE_W'(1) << BYTE_W) : '0);
   assign narrow_o = rounded[BYTE_W +: ELEM_W];
   assign wide_o   = rounded;
endmodule

// File: rtl/pm_pack.sv
module pm_pack
   import pm_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int ELEM_W = 16,
   localparam int DATA_W     = LANES * ELEM_W,
   localparam int WIDE_W     = 2 * ELEM_W,
   localparam int WIDE_LANES = LANES / 2
) (
   input  pm_op_e            op,
   input  logic [ELEM_W-1:0] narrow [LANES],
   input  logic [WIDE_W-1:0] wide   [LANES],
   output logic [DATA_W-1:0] packed_o
);
   logic [DATA_W-1:0] narrow_cat, wide_cat;

   for (genvar r = 0; r < LANES; r++) begin : g_n
      assign narrow_cat[r*ELEM_W +: ELEM_W] = narrow[r];
   end
   for (genvar w = 0; w < WIDE_LANES; w++) begin : g_w
      assign wide_cat[w*WIDE_W +: WIDE_W] = wide[w];
   end

   always_comb begin
      if (pm_is_narrow(op))    packed_o = narrow_cat;
      else if (pm_is_wide(op)) packed_o = wide_cat;
      else                     packed_o = '0;
   end
endmodule

// File: rtl/simd_scale_mul.sv
module simd_scale_mul
   import pm_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int ELEM_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [2:0]                opcode,
   input  logic [LANES*ELEM_W-1:0]   pix_i,
   input  logic [LANES*ELEM_W-1:0]   scl_i,
   output logic                      out_valid,
   output logic [LANES*ELEM_W-1:0]   result
);
   localparam int DATA_W = LANES * ELEM_W;
   localparam int WIDE_W = 2 * ELEM_W;

   if (ELEM_W != 2 * BYTE_W) begin : g_bad_elem
      $error("ELEM_W must be twice BYTE_W");
   end
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("LANES must be even and at least 2");
   end

   pm_op_e op;
   assign op = pm_op_e'(opcode);

   logic signed [ELEM_W-1:0] scale [LANES];
   logic signed [BYTE_W:0]   mcand [LANES];
   logic [ELEM_W-1:0]        narrow [LANES];
   logic [WIDE_W-1:0]        wide   [LANES];
   logic [DATA_W-1:0]        packed_res;

   pm_operand_sel #(.LANES(LANES), .BYTE_W(BYTE_W), .ELEM_W(ELEM_W)) u_sel (
      .op(op), .pix(pix_i), .scl(scl_i), .scale_o(scale), .mcand_o(mcand)
   );

   for (genvar r = 0; r < LANES; r++) begin : g_mul
      pm_lane_mul #(.BYTE_W(BYTE_W), .ELEM_W(ELEM_W)) u_mul (
         .scale(scale[r]), .mcand(mcand[r]),
         .narrow_o(narrow[r]), .wide_o(wide[r])
      );
   end

   pm_pack #(.LANES(LANES), .ELEM_W(ELEM_W)) u_pack (
      .op(op), .narrow(narrow), .wide(wide), .packed_o(packed_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= packed_res;
      end
   end

   // R2: valid flag lags the strobe by one cycle
   a_r2_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R2: result holds when nothing is accepted
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(result));

   // R11: reserved opcode gives zero
   a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && opcode == 3'd7) |-> result == '0);

   // R3: a zero pixel operand makes every product, and so every lane, zero
   a_r3_zero_pixels: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pix_i == '0) |-> result == '0);

   // R1: first edge after reset release sees no valid output
   a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/tb_simd_scale_mul.sv
`timescale 1ns/1ps
module tb_simd_scale_mul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  opcode = '0;
   logic [63:0] pix_i = '0;
   logic [63:0] scl_i = '0;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   simd_scale_mul dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .pix_i(pix_i), .scl_i(scl_i), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(input logic [2:0] op,
                                         input logic [63:0] p,
                                         input logic [63:0] s);
      logic [63:0] res;
      res = '0;
      for (int r = 0; r < 4; r++) begin
         int sc, mc;
         logic [31:0] pr;
         sc = int'($signed(s[16*r +: 16]));
         if (op == 3'd1) sc = int'($signed(s[31:16]));
         if (op == 3'd2) sc = int'($signed(s[15:0]));
         case (op)
            3'd0, 3'd1, 3'd2: mc = int'(p[8*r +: 8]);
            3'd3, 3'd5:       mc = int'($signed(p[16*r+8 +: 8]));
            3'd4, 3'd6:       mc = int'(p[16*r +: 8]);
            default:          mc = 0;
         endcase
         pr = sc * mc;
         if (pr[7:0] > 8'h7F) pr = pr + 32'h100;
         if (op <= 3'd4) res[16*r +: 16] = pr[23:8];
         else if (op <= 3'd6 && r < 2) res[32*r +: 32] = pr;
      end
      return res;
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [2:0] op,
                         input logic [63:0] p, input logic [63:0] s,
                         input logic [63:0] exp);
      @(negedge clk);
      in_valid = 1'b1; opcode = op; pix_i = p; scl_i = s;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
      check(tag, result, exp);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset result", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release valid", {63'd0, out_valid}, 64'd0);
      check("R1 after release result", result, 64'd0);

      // R3: rounding boundary, scale 1, bytes 7F 80 81 FF
      run_op("R3 round", 3'd0, 64'h00000000_FF81807F, 64'h0001_0001_0001_0001,
             64'h0001_0001_0001_0000);
      // R4: negative scales
      run_op("R4 negative", 3'd0, 64'h00000000_00000201, 64'h0000_0000_FF00_FFFF,
             64'h0000_0000_FFFE_0000);
      run_op("R5 broadcast e1", 3'd1, 64'h00000000_04030201, 64'h7777_6666_0100_5555,
             64'h0004_0003_0002_0001);
      run_op("R6 broadcast e0", 3'd2, 64'h00000000_04030201, 64'h7777_6666_1111_0200,
             64'h0008_0006_0004_0002);
      run_op("R7 upper signed", 3'd3, 64'h01AA_80BB_7FCC_FFDD, 64'h0100_0100_0100_0100,
             64'h0001_FF80_007F_FFFF);
      run_op("R8 lower unsigned", 3'd4, 64'h01AA_80BB_7FCC_FFDD, 64'h0100_0100_0100_0100,
             64'h00AA_00BB_00CC_00DD);
      run_op("R9 wide signed", 3'd5, 64'h0000_0000_0155_80AA, 64'h0000_0000_0003_0100,
             64'h00000003_FFFF8000);
      run_op("R10 wide unsigned", 3'd6, 64'h0000_0000_FF10_7780, 64'h0000_0000_0002_FFFF,
             64'h00000020_00000080);
      run_op("R11 reserved", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
             64'd0);

      // R2: hold while strobe low, with inputs changing
      run_op("R2 load", 3'd2, 64'h00000000_04030201, 64'h0000_0000_0000_0200,
             64'h0008_0006_0004_0002);
      held = result;
      @(negedge clk);
      opcode = 3'd0; pix_i = 64'hFFFF_FFFF_FFFF_FFFF; scl_i = 64'h7FFF_7FFF_7FFF_7FFF;
      @(negedge clk);
      check("R2 hold valid", {63'd0, out_valid}, 64'd0);
      check("R2 hold result", result, held);

      // Random operands across every opcode (R3-R11)
      for (int i = 0; i < 400; i++) begin
         logic [2:0]  op;
         logic [63:0] p, s;
         op = 3'($urandom_range(0, 7));
         p  = {$urandom(), $urandom()};
         s  = {$urandom(), $urandom()};
         if (i % 16 == 0) s = {4{16'h8000}};
         if (i % 16 == 1) p = {8{8'hFF}};
         run_op($sformatf("R3 random op %0d", op), op, p, s, model(op, p, s));
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule